// File: doc/BRIEF.md
# SD Command Issue Register Block

This block is the software-facing front of an SD/MMC host command path. Software writes a 32-bit argument and then a command word. Setting the pending flag in that word launches the command: the block pulses a start strobe to a card-side command engine and holds the index, flags and argument steady on its outputs until the engine answers with a done strobe. The done strobe may carry an error indication with an error kind.

On completion the block clears the pending flag. On error it also sets a fail flag in the command word and the matching sticky error bit in the status word, all on the same clock edge. On success it captures the card response into four 32-bit response words. A long response fills all four words. A short response fills only the lowest word.

The status word also collects sticky event bits from the data side and mirrors a live data-available level. Software clears each sticky bit by writing 1 to it. The block also holds a block byte count and a 9-bit block count, which it drives to the data path. Every register is reached through one flat read/write register port. Reads are combinational.

Top module: `sdcmd_regblk`

## Requirements
- R1: After reset every mapped register reads zero, no command is pending and `eng_start` is low.
- R2: A write to offset 0x00 with bit 15 set, made while no command is pending, has these effects. The command word then reads back with bit 15 set and bit 14 clear. `eng_start` is high for exactly one cycle, the cycle after the write. The engine outputs show the fields: index in bits 5:0, read-data at bit 6, write-data at bit 7, long response at bit 9, no response at bit 10, wait-for-busy at bit 11. `eng_arg` shows the argument written at offset 0x04.
- R3: While a command is pending, writes to offsets 0x00 and 0x04 are ignored. The readback and engine outputs keep the earlier command, and no new `eng_start` pulse occurs.
- R4: A done strobe without error, taken while pending, clears bit 15 on that same edge and leaves bit 14 clear.
- R5: A done strobe with error, taken while pending, clears bit 15 and sets bit 14 on the same edge. It also sets one status bit chosen by `eng_err_kind`: 0 sets command timeout (bit 6), 1 sets CRC7 error (bit 4), 2 sets CRC16 error (bit 5), 3 sets read/erase/write timeout (bit 7).
- R6: A successful completion of a long-response command loads the response words at 0x10, 0x14, 0x18 and 0x1C with `eng_rsp` bits 31:0, 63:32, 95:64 and 127:96 respectively.
- R7: A successful completion of a short-response command loads only 0x10. A completion with no response, or with error, loads no response word.
- R8: The pulses `evt_busy_done`, `evt_block`, `evt_sdio` and `evt_fifo_err` set sticky status bits 10, 9, 8 and 3. Status bit 0 mirrors `dat_avail`. Bits 2:1 read zero.
- R9: Writing the status word at 0x20 clears each sticky bit written as 1 and keeps each bit written as 0. A set arriving in the same cycle as a clear leaves the bit set. Bit 0 cannot be cleared by a write.
- R10: Offset 0x3C holds a 16-bit byte count and offset 0x50 a 9-bit block count. Upper written bits are dropped. Both values drive `eng_byte_cnt` and `eng_blk_cnt`.
- R11: A done strobe with no command pending changes nothing. Writes to the response words have no effect. Reads of unmapped or misaligned offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| eng_start | output | 1 | One-cycle launch strobe to the command engine |
| eng_idx | output | 6 | Command index |
| eng_rd | output | 1 | Command reads data |
| eng_wr | output | 1 | Command writes data |
| eng_long | output | 1 | 136-bit response expected |
| eng_noresp | output | 1 | No response expected |
| eng_busy | output | 1 | Wait for busy release after response |
| eng_arg | output | 32 | Command argument |
| eng_done | input | 1 | Engine completion strobe |
| eng_err | input | 1 | Completion ended in error (valid with `eng_done`) |
| eng_err_kind | input | 2 | Error kind (valid with `eng_err`) |
| eng_rsp | input | 128 | Response bits (valid with `eng_done`) |
| evt_busy_done | input | 1 | Busy-release event pulse |
| evt_block | input | 1 | Block-complete event pulse |
| evt_sdio | input | 1 | SDIO card event pulse |
| evt_fifo_err | input | 1 | Data FIFO error pulse |
| dat_avail | input | 1 | Live data-available level |
| eng_byte_cnt | output | 16 | Bytes per block |
| eng_blk_cnt | output | 9 | Block count |

## Verification
A pending flag stuck high or low shows up in two ways. The command word readback returns the wrong bit 15 on the next read. `eng_start` is either missing in the cycle after the launch write, or it repeats after a blocked rewrite. A mis-steered completion shows on the first read after the done edge: a wrong fail bit, a wrong status bit, or a response word that changed when it should have held. The bench sweeps command indices, flag mixes and all four error kinds, and it keeps an independent model of the four response words and the status word. A capture-enable or clear-mask fault therefore diverges from that model within one command.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int DW = 32;

    // register byte offsets
    localparam int OFS_CMD   = 'h00;
    localparam int OFS_ARG   = 'h04;
    localparam int OFS_RSP0  = 'h10;
    localparam int OFS_STS   = 'h20;
    localparam int OFS_BYTES = 'h3C;
    localparam int OFS_BLKS  = 'h50;

    // command word bit positions
    localparam int CB_RD   = 6;
    localparam int CB_WR   = 7;
    localparam int CB_LONG = 9;
    localparam int CB_NORS = 10;
    localparam int CB_BUSY = 11;
    localparam int CB_FAIL = 14;
    localparam int CB_PEND = 15;

    // status word
    localparam int STS_W        = 11;
    localparam int SB_BUSY_DONE = 10;
    localparam int SB_BLOCK     = 9;
    localparam int SB_SDIO      = 8;
    localparam int SB_REW_TOUT  = 7;
    localparam int SB_CMD_TOUT  = 6;
    localparam int SB_CRC16     = 5;
    localparam int SB_CRC7      = 4;
    localparam int SB_FIFO      = 3;
    localparam int SB_DAT       = 0;
    localparam logic [STS_W-1:0] STICKY_MASK = 11'b111_1111_1000;

    typedef struct packed {
        logic       busy;
        logic       noresp;
        logic       longrsp;
        logic       wr_data;
        logic       rd_data;
        logic [5:0] idx;
    } cmd_fields_t;

    typedef enum logic [1:0] {
        ERR_CMD_TOUT = 2'd0,
        ERR_CRC7     = 2'd1,
        ERR_CRC16    = 2'd2,
        ERR_REW_TOUT = 2'd3
    } err_kind_t;

    function automatic cmd_fields_t unpack_cmd(input logic [15:0] w);
        cmd_fields_t f;
        f.idx     = w[5:0];
        f.rd_data = w[CB_RD];
        f.wr_data = w[CB_WR];
        f.longrsp = w[CB_LONG];
        f.noresp  = w[CB_NORS];
        f.busy    = w[CB_BUSY];
        return f;
    endfunction

    function automatic logic [15:0] pack_cmd(input cmd_fields_t f,
                                             input logic fail,
                                             input logic pend);
        logic [15:0] w;
        w          = '0;
        w[5:0]     = f.idx;
        w[CB_RD]   = f.rd_data;
        w[CB_WR]   = f.wr_data;
        w[CB_LONG] = f.longrsp;
        w[CB_NORS] = f.noresp;
        w[CB_BUSY] = f.busy;
        w[CB_FAIL] = fail;
        w[CB_PEND] = pend;
        return w;
    endfunction

    function automatic logic [STS_W-1:0] err_to_sts(input err_kind_t k);
        logic [STS_W-1:0] s;
        s = '0;
        unique case (k)
            ERR_CMD_TOUT: s[SB_CMD_TOUT] = 1'b1;
            ERR_CRC7:     s[SB_CRC7]     = 1'b1;
            ERR_CRC16:    s[SB_CRC16]    = 1'b1;
            ERR_REW_TOUT: s[SB_REW_TOUT] = 1'b1;
            default:      s              = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sdcmd_issue.sv
module sdcmd_issue
    import sdcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic              arg_we,
    input  logic [DW-1:0]     wdata,
    input  logic              eng_done,
    input  logic              eng_err,
    output cmd_fields_t       fields,
    output logic [DW-1:0]     arg,
    output logic              pend,
    output logic              fail,
    output logic              start
);

    cmd_fields_t   fields_q;
    logic [DW-1:0] arg_q;
    logic          pend_q;
    logic          fail_q;
    logic          start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= '0;
            arg_q    <= '0;
            pend_q   <= 1'b0;
            fail_q   <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (pend_q) begin
                // launched command is frozen until the engine answers
                if (eng_done) begin
                    pend_q <= 1'b0;
                    fail_q <= eng_err;
                end
            end else begin
                if (cmd_we) begin
                    fields_q <= unpack_cmd(wdata[15:0]);
                    fail_q   <= 1'b0;
                    pend_q   <= wdata[CB_PEND];
                    start_q  <= wdata[CB_PEND];
                end
                if (arg_we) begin
                    arg_q <= wdata;
                end
            end
        end
    end

    assign fields = fields_q;
    assign arg    = arg_q;
    assign pend   = pend_q;
    assign fail   = fail_q;
    assign start  = start_q;

endmodule

// File: rtl/sdcmd_resp.sv
module sdcmd_resp
    import sdcmd_pkg::*;
#(
    parameter int RSP_WORDS = 4,
    localparam int RSP_W = RSP_WORDS * DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic             longrsp,
    input  logic [RSP_W-1:0] rsp_in,
    output logic [RSP_W-1:0] rsp_q
);

    for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
        logic [DW-1:0] word_q;
        logic          load;

        if (w == 0) begin : g_low
            assign load = cap;
        end else begin : g_high
            assign load = cap & longrsp;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
            end else if (load) begin
                word_q <= rsp_in[w*DW +: DW];
            end
        end

        assign rsp_q[w*DW +: DW] = word_q;
    end

endmodule

// File: rtl/sdcmd_status.sv
module sdcmd_status
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [STS_W-1:0] set,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr,
    input  logic             dat_avail,
    output logic [STS_W-1:0] word
);

    for (genvar b = 0; b < STS_W; b++) begin : g_bit
        if (STICKY_MASK[b]) begin : g_sticky
            logic bit_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bit_q <= 1'b0;
                end else if (set[b]) begin
                    bit_q <= 1'b1;
                end else if (clr_we && clr[b]) begin
                    bit_q <= 1'b0;
                end
            end
            assign word[b] = bit_q;
        end else if (b == SB_DAT) begin : g_live
            assign word[b] = dat_avail;
        end else begin : g_zero
            assign word[b] = 1'b0;
        end
    end

endmodule

// File: rtl/sdcmd_regblk.sv
module sdcmd_regblk
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int RSP_WORDS = 4,
    parameter int BYTECNT_W = 16,
    parameter int BLKCNT_W  = 9,
    localparam int RSP_W     = RSP_WORDS * DW,
    localparam int RSP_SEL_W = (RSP_WORDS > 1) ? $clog2(RSP_WORDS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    output logic                 eng_start,
    output logic [5:0]           eng_idx,
    output logic                 eng_rd,
    output logic                 eng_wr,
    output logic                 eng_long,
    output logic                 eng_noresp,
    output logic                 eng_busy,
    output logic [DW-1:0]        eng_arg,
    input  logic                 eng_done,
    input  logic                 eng_err,
    input  logic [1:0]           eng_err_kind,
    input  logic [RSP_W-1:0]     eng_rsp,
    input  logic                 evt_busy_done,
    input  logic                 evt_block,
    input  logic                 evt_sdio,
    input  logic                 evt_fifo_err,
    input  logic                 dat_avail,
    output logic [BYTECNT_W-1:0] eng_byte_cnt,
    output logic [BLKCNT_W-1:0]  eng_blk_cnt
);

    localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_ARG   = ADDR_W'(OFS_ARG);
    localparam logic [ADDR_W-1:0] A_RSP0  = ADDR_W'(OFS_RSP0);
    localparam logic [ADDR_W-1:0] A_RSPN  = ADDR_W'(OFS_RSP0 + 4 * (RSP_WORDS - 1));
    localparam logic [ADDR_W-1:0] A_STS   = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_BYTES = ADDR_W'(OFS_BYTES);
    localparam logic [ADDR_W-1:0] A_BLKS  = ADDR_W'(OFS_BLKS);

    // ---------------- write decode ----------------
    logic cmd_we, arg_we, sts_we, bytes_we, blks_we;
    assign cmd_we   = reg_wr && (reg_addr == A_CMD);
    assign arg_we   = reg_wr && (reg_addr == A_ARG);
    assign sts_we   = reg_wr && (reg_addr == A_STS);
    assign bytes_we = reg_wr && (reg_addr == A_BYTES);
    assign blks_we  = reg_wr && (reg_addr == A_BLKS);

    // ---------------- command issue ----------------
    cmd_fields_t   fields;
    logic [DW-1:0] arg;
    logic          pend;
    logic          fail;

    sdcmd_issue u_issue (
        .clk      (clk),
        .rst      (rst),
        .cmd_we   (cmd_we),
        .arg_we   (arg_we),
        .wdata    (reg_wdata),
        .eng_done (eng_done),
        .eng_err  (eng_err),
        .fields   (fields),
        .arg      (arg),
        .pend     (pend),
        .fail     (fail),
        .start    (eng_start)
    );

    assign eng_idx    = fields.idx;
    assign eng_rd     = fields.rd_data;
    assign eng_wr     = fields.wr_data;
    assign eng_long   = fields.longrsp;
    assign eng_noresp = fields.noresp;
    assign eng_busy   = fields.busy;
    assign eng_arg    = arg;

    // completion is only honoured while a command is outstanding
    logic done_take;
    logic rsp_cap;
    assign done_take = pend && eng_done;
    assign rsp_cap   = done_take && !eng_err && !fields.noresp;

    // ---------------- response capture ----------------
    logic [RSP_W-1:0] rsp_q;

    sdcmd_resp #(
        .RSP_WORDS (RSP_WORDS)
    ) u_resp (
        .clk     (clk),
        .rst     (rst),
        .cap     (rsp_cap),
        .longrsp (fields.longrsp),
        .rsp_in  (eng_rsp),
        .rsp_q   (rsp_q)
    );

    // ---------------- status ----------------
    logic [STS_W-1:0] sts_set;
    logic [STS_W-1:0] sts_word;
    logic [STS_W-1:0] err_bits;

    assign err_bits = err_to_sts(err_kind_t'(eng_err_kind));

    always_comb begin
        sts_set               = '0;
        sts_set[SB_BUSY_DONE] = evt_busy_done;
        sts_set[SB_BLOCK]     = evt_block;
        sts_set[SB_SDIO]      = evt_sdio;
        sts_set[SB_FIFO]      = evt_fifo_err;
        if (done_take && eng_err) begin
            sts_set = sts_set | err_bits;
        end
    end

    sdcmd_status u_status (
        .clk       (clk),
        .rst       (rst),
        .set       (sts_set),
        .clr_we    (sts_we),
        .clr       (reg_wdata[STS_W-1:0]),
        .dat_avail (dat_avail),
        .word      (sts_word)
    );

    // ---------------- transfer size registers ----------------
    logic [BYTECNT_W-1:0] bytes_q;
    logic [BLKCNT_W-1:0]  blks_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bytes_q <= '0;
            blks_q  <= '0;
        end else begin
            if (bytes_we) bytes_q <= reg_wdata[BYTECNT_W-1:0];
            if (blks_we)  blks_q  <= reg_wdata[BLKCNT_W-1:0];
        end
    end

    assign eng_byte_cnt = bytes_q;
    assign eng_blk_cnt  = blks_q;

    // ---------------- read mux ----------------
    logic [RSP_SEL_W-1:0] rsp_sel;
    logic                 rsp_hit;
    assign rsp_sel = reg_addr[RSP_SEL_W+1:2];
    assign rsp_hit = (reg_addr >= A_RSP0) && (reg_addr <= A_RSPN) &&
                     (reg_addr[1:0] == 2'b00);

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CMD) begin
            reg_rdata[15:0] = pack_cmd(fields, fail, pend);
        end else if (reg_addr == A_ARG) begin
            reg_rdata = arg;
        end else if (reg_addr == A_STS) begin
            reg_rdata[STS_W-1:0] = sts_word;
        end else if (reg_addr == A_BYTES) begin
            reg_rdata[BYTECNT_W-1:0] = bytes_q;
        end else if (reg_addr == A_BLKS) begin
            reg_rdata[BLKCNT_W-1:0] = blks_q;
        end else if (rsp_hit) begin
            reg_rdata = rsp_q[rsp_sel*DW +: DW];
        end
    end

endmodule

// File: rtl/sdcmd_regblk_chk.sv
module sdcmd_regblk_chk (
    input logic clk,
    input logic rst,
    input logic pend,
    input logic fail,
    input logic eng_start,
    input logic eng_done,
    input logic eng_err
);

    // R2: launch strobe is a single-cycle pulse
    p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R2: a launch strobe is always accompanied by a pending command
    p_start_pending_r2: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> pend);

    // R3: no relaunch can come out of a pending command
    p_no_relaunch_r3: assert property (@(posedge clk) disable iff (rst)
        pend |=> !eng_start);

    // R3: only the engine can end a pending command
    p_pend_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (pend && !eng_done) |=> pend);

    // R4: completion clears pending on the same edge
    p_done_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (pend && eng_done) |=> !pend);

    // R4: clean completion leaves fail low
    p_clean_no_fail_r4: assert property (@(posedge clk) disable iff (rst)
        (pend && eng_done && !eng_err) |=> !fail);

    // R5: error completion raises fail
    p_err_sets_fail_r5: assert property (@(posedge clk) disable iff (rst)
        (pend && eng_done && eng_err) |=> fail);

    // R11: a stray done strobe leaves the fail flag alone
    p_stray_done_r11: assert property (@(posedge clk) disable iff (rst)
        (!pend && eng_done && !eng_start) |=> (!pend && $stable(fail)) || eng_start);

endmodule

bind sdcmd_regblk sdcmd_regblk_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .fail      (fail),
    .eng_start (eng_start),
    .eng_done  (eng_done),
    .eng_err   (eng_err)
);

// File: tb/sdcmd_regblk_bench.sv
module sdcmd_regblk_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         eng_start;
    logic [5:0]   eng_idx;
    logic         eng_rd, eng_wr, eng_long, eng_noresp, eng_busy;
    logic [31:0]  eng_arg;
    logic         eng_done = 1'b0;
    logic         eng_err = 1'b0;
    logic [1:0]   eng_err_kind = '0;
    logic [127:0] eng_rsp = '0;
    logic         evt_busy_done = 1'b0, evt_block = 1'b0, evt_sdio = 1'b0, evt_fifo_err = 1'b0;
    logic         dat_avail = 1'b0;
    logic [15:0]  eng_byte_cnt;
    logic [8:0]   eng_blk_cnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sdcmd_regblk u_sdcmd_regblk (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_start(eng_start), .eng_idx(eng_idx), .eng_rd(eng_rd), .eng_wr(eng_wr),
        .eng_long(eng_long), .eng_noresp(eng_noresp), .eng_busy(eng_busy), .eng_arg(eng_arg),
        .eng_done(eng_done), .eng_err(eng_err), .eng_err_kind(eng_err_kind), .eng_rsp(eng_rsp),
        .evt_busy_done(evt_busy_done), .evt_block(evt_block), .evt_sdio(evt_sdio),
        .evt_fifo_err(evt_fifo_err), .dat_avail(dat_avail),
        .eng_byte_cnt(eng_byte_cnt), .eng_blk_cnt(eng_blk_cnt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_done(input logic err, input logic [1:0] kind, input logic [127:0] rsp);
        @(negedge clk);
        eng_done = 1'b1; eng_err = err; eng_err_kind = kind; eng_rsp = rsp;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0;
    endtask

    function automatic logic [31:0] err_bit(input logic [1:0] k);
        case (k)
            2'd0: return 32'h40;
            2'd1: return 32'h10;
            2'd2: return 32'h20;
            default: return 32'h80;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0]  rd;
        logic [31:0]  exp_rsp [4];
        logic [127:0] rsp;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset sweep over every word offset
        for (int a = 0; a < 'h60; a += 4) begin
            bus_rd(8'(a), rd);
            chk($sformatf("R1 reset offset %0h", a), rd, 32'h0);
        end
        chk("R1 start low", {31'b0, eng_start}, 32'h0);
        for (int k = 0; k < 4; k++) exp_rsp[k] = '0;

        // R2..R7 sweep over commands
        for (int i = 0; i < 48; i++) begin
            logic [5:0]  idx;
            logic        lg, nr, rdf, wrf, bz, er;
            logic [1:0]  kind;
            logic [31:0] word, arg;
            idx  = 6'((i * 7) % 64);
            lg   = (i % 3 == 1);
            nr   = (i % 3 == 2);
            rdf  = i[0];
            wrf  = i[1];
            bz   = i[2];
            er   = (i % 4 == 3);
            kind = 2'((i / 4) % 4);
            arg  = 32'h1000_0000 + 32'(i) * 32'h0001_0203;
            word = {16'b0, 1'b1, 1'b0, 2'b0, bz, nr, lg, 1'b0, wrf, rdf, idx};

            bus_wr(8'h04, arg);
            bus_wr(8'h00, word);
            chk("R2 start pulse", {31'b0, eng_start}, 32'h1);
            chk("R2 index out", {26'b0, eng_idx}, {26'b0, idx});
            chk("R2 flags out", {27'b0, eng_busy, eng_noresp, eng_long, eng_wr, eng_rd},
                {27'b0, bz, nr, lg, wrf, rdf});
            chk("R2 arg out", eng_arg, arg);
            bus_rd(8'h00, rd);
            chk("R2 readback", rd, word);
            @(negedge clk);
            chk("R2 start one cycle", {31'b0, eng_start}, 32'h0);

            if (i % 6 == 0) begin
                bus_wr(8'h00, 32'h0000_803F);
                chk("R3 no relaunch", {31'b0, eng_start}, 32'h0);
                bus_wr(8'h04, 32'hDEAD_BEEF);
                bus_rd(8'h00, rd);
                chk("R3 cmd kept", rd, word);
                bus_rd(8'h04, rd);
                chk("R3 arg kept", rd, arg);
                chk("R3 idx out kept", {26'b0, eng_idx}, {26'b0, idx});
            end

            rsp = {32'(i) * 32'h0101_0101 ^ 32'hA5A5_0000, 32'hC000_0000 + 32'(i),
                   32'h0F0F_0000 ^ 32'(i * 3), 32'h8000_0000 | 32'(i * 11)};
            pulse_done(er, kind, rsp);
            if (!er && !nr) begin
                exp_rsp[0] = rsp[31:0];
                if (lg) begin
                    exp_rsp[1] = rsp[63:32];
                    exp_rsp[2] = rsp[95:64];
                    exp_rsp[3] = rsp[127:96];
                end
            end
            bus_rd(8'h00, rd);
            if (er) chk("R5 pend clear fail set", rd, (word & ~32'h8000) | 32'h4000);
            else    chk("R4 pend clear", rd, word & ~32'h8000);
            for (int k = 0; k < 4; k++) begin
                bus_rd(8'(8'h10 + 4 * k), rd);
                chk(lg ? "R6 long response" : "R7 short/none response", rd, exp_rsp[k]);
            end
            bus_rd(8'h20, rd);
            chk("R5 status bit", rd, er ? err_bit(kind) : 32'h0);
            bus_wr(8'h20, 32'h0000_07F8);
            bus_rd(8'h20, rd);
            chk("R9 clear all", rd, 32'h0);
        end

        // R8: event pulses and live data flag
        @(negedge clk);
        evt_busy_done = 1; evt_block = 1;
        @(negedge clk);
        evt_busy_done = 0; evt_block = 0; evt_sdio = 1; evt_fifo_err = 1;
        @(negedge clk);
        evt_sdio = 0; evt_fifo_err = 0; dat_avail = 1;
        bus_rd(8'h20, rd);
        chk("R8 sticky events", rd, 32'h0000_0709);
        dat_avail = 0;
        bus_rd(8'h20, rd);
        chk("R8 data flag live", rd, 32'h0000_0708);

        // R9: partial clear keeps zero-written bits
        dat_avail = 1;
        bus_wr(8'h20, 32'h0000_0201);
        bus_rd(8'h20, rd);
        chk("R9 partial clear", rd, 32'h0000_0509);
        dat_avail = 0;
        // R9: set wins over same-cycle clear
        @(negedge clk);
        reg_addr = 8'h20; reg_wdata = 32'h0000_0100; reg_wr = 1; evt_sdio = 1;
        @(negedge clk);
        reg_wr = 0; evt_sdio = 0;
        bus_rd(8'h20, rd);
        chk("R9 set beats clear", rd, 32'h0000_0508);
        bus_wr(8'h20, 32'hFFFF_FFFF);
        bus_rd(8'h20, rd);
        chk("R9 clear rest", rd, 32'h0);

        // R10: size registers
        bus_wr(8'h50, 32'hFFFF_FFFF);
        bus_rd(8'h50, rd);
        chk("R10 block count width", rd, 32'h1FF);
        chk("R10 block count out", {23'b0, eng_blk_cnt}, 32'h1FF);
        bus_wr(8'h3C, 32'h1234_5678);
        bus_rd(8'h3C, rd);
        chk("R10 byte count width", rd, 32'h5678);
        chk("R10 byte count out", {16'b0, eng_byte_cnt}, 32'h5678);

        // R11: stray done, response write, unmapped reads
        bus_wr(8'h00, 32'h0000_0005);
        pulse_done(1'b1, 2'd1, {4{32'h7777_7777}});
        bus_rd(8'h00, rd);
        chk("R11 stray done cmd", rd, 32'h0000_0005);
        bus_rd(8'h20, rd);
        chk("R11 stray done status", rd, 32'h0);
        bus_rd(8'h10, rd);
        chk("R11 stray done rsp", rd, exp_rsp[0]);
        bus_wr(8'h10, 32'h1234_4321);
        bus_rd(8'h10, rd);
        chk("R11 rsp write ignored", rd, exp_rsp[0]);
        bus_rd(8'h08, rd);
        chk("R11 unmapped 08", rd, 32'h0);
        bus_rd(8'h24, rd);
        chk("R11 unmapped 24", rd, 32'h0);
        bus_rd(8'h12, rd);
        chk("R11 misaligned 12", rd, 32'h0);
        bus_rd(8'h20, rd);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule